// File: doc/BRIEF.md
# Prescaled Free-Running Timer Counter

This block keeps a 16-bit time base for the rest of the chip. The counter counts up without ever stopping. It advances once per prescaled tick, and the tick comes from the system clock divided by one of four ratios. Software can read the count through a small byte-wide register port. It cannot load, clear or pause the count.

When the count rolls over from its top value to zero, an overflow flag is set. Software clears the flag by writing a 1 to it. An interrupt request is raised while both the flag and its enable bit are set. Software can extend the timer's range by counting overflows. It can also measure an interval by clearing the flag and then polling it.

The divider restarts whenever the ratio select changes. The first tick at a new ratio is therefore always a full period long.

Top module: `freerun_timer`

## Requirements
- R1: While reset is asserted and right after it, the count, the mask register, the flag register and `irq` all read as zero. The counter then advances from 0 at ratio 1.
- R2: The count increases by exactly one per prescaled tick and wraps modulo 65536.
- R3: Mask bits 1:0 select the division ratio: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 16. The mask register reads back as enable in bit 7, select in bits 1:0 and zero elsewhere.
- R4: Flag register bit 7 is the overflow flag. It is set on the clock edge where the count goes from 0xFFFF to 0x0000. It reads as zero when the count is 0xFFFF and no overflow has happened.
- R5: Writing to offset 3 with bit 7 = 1 clears the overflow flag. Writing with bit 7 = 0 leaves the flag unchanged.
- R6: `irq` equals the overflow flag ANDed with mask bit 7. With the enable at 0, `irq` stays low even while the flag is set.
- R7: Offset 0 reads the high byte of the count and offset 1 reads the low byte. Read data follows `bus_addr` in the same cycle, so both bytes can be read between two clock edges.
- R8: If a wrap and a write-1 clear happen on the same edge, the flag ends up set.
- R9: Suppose a write changes the ratio select to a new ratio N. The count then does not advance on the next N rising edges after the write edge, and it advances on edge N+1.
- R10: Writes to offsets 0 and 1 have no effect. The count keeps its exact progression.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset: 0 count high, 1 count low, 2 mask, 3 flags |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach from the ports is a write-1 clear that lands on the exact edge where the count wraps. The bench first reads the count coherently within one low clock phase. It then computes how many edges remain until the count reaches 0xFFFF, waits exactly that many, and drives the clear so that its edge is the wrap edge.

A similar problem arises with divider restarts and ratio checks, because the divider phase is not visible at the ports. Ratios are therefore checked over windows that are whole multiples of the ratio, which gives an exact count difference whatever the phase. Restarts are checked edge by edge from the write edge.

// File: rtl/freerun_pkg.sv
`timescale 1ns/1ps
package freerun_pkg;
   localparam int DATA_W    = 8;
   localparam int MAX_RATIO = 16;
   localparam int DIV_W     = $clog2(MAX_RATIO);

   typedef enum logic [1:0] {
      SEL_DIV1  = 2'b00,
      SEL_DIV4  = 2'b01,
      SEL_DIV8  = 2'b10,
      SEL_DIV16 = 2'b11
   } ps_sel_e;

   localparam logic [1:0] OFS_CNT_HI = 2'd0;
   localparam logic [1:0] OFS_CNT_LO = 2'd1;
   localparam logic [1:0] OFS_MASK   = 2'd2;
   localparam logic [1:0] OFS_FLAG   = 2'd3;

   localparam int EN_BIT  = 7;
   localparam int OVF_BIT = 7;

   function automatic int unsigned ps_ratio(input ps_sel_e s);
      case (s)
         SEL_DIV1:  return 1;
         SEL_DIV4:  return 4;
         SEL_DIV8:  return 8;
         default:   return 16;
      endcase
   endfunction
endpackage

// File: rtl/freerun_prescaler.sv
`timescale 1ns/1ps
module freerun_prescaler
   import freerun_pkg::*;
#(
   parameter int DW = DIV_W
) (
   input  logic    clk,
   input  logic    rst_n,
   input  ps_sel_e sel_i,
   output logic    tick_o
);
   localparam int LIM_MAX = (1 << DW) - 1;

   if (LIM_MAX < MAX_RATIO - 1) begin : g_bad_width
      $error("freerun_prescaler: DW too narrow for the largest ratio");
   end

   ps_sel_e        sel_seen_q;
   logic [DW-1:0]  div_q;
   logic [DW-1:0]  div_lim;
   logic           restart;

   always_comb div_lim = DW'(ps_ratio(sel_i) - 1);
   assign restart = (sel_i != sel_seen_q);
   assign tick_o  = !restart && (div_q == div_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_seen_q <= SEL_DIV1;
         div_q      <= '0;
      end else begin
         sel_seen_q <= sel_i;
         if (restart || div_q == div_lim) div_q <= '0;
         else                             div_q <= div_q + 1'b1;
      end
   end

   // R9: no tick in the cycle right after the select changes
   assert_restart_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sel_i) |-> !tick_o);
endmodule

// File: rtl/freerun_counter.sv
`timescale 1ns/1ps
module freerun_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("freerun_counter: CNT_W must be at least 2");
   end

   assign wrap_o = tick_i && (&cnt_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_o <= '0;
      else if (tick_i) cnt_o <= cnt_o + 1'b1;
   end

   assert_step_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> cnt_o == $past(cnt_o) + CNT_W'(1));
   assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/freerun_ctrl_regs.sv
`timescale 1ns/1ps
module freerun_ctrl_regs
   import freerun_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [1:0]        addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              wrap_i,
   output ps_sel_e           sel_o,
   output logic              ovf_en_o,
   output logic              ovf_flag_o,
   output logic              irq_o
);
   logic mask_wr;
   logic flag_clr;
   logic unused_wdata;

   assign mask_wr      = wr_i && (addr_i == OFS_MASK);
   assign flag_clr     = wr_i && (addr_i == OFS_FLAG) && wdata_i[OVF_BIT];
   assign unused_wdata = ^wdata_i[6:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_o    <= SEL_DIV1;
         ovf_en_o <= 1'b0;
      end else if (mask_wr) begin
         sel_o    <= ps_sel_e'(wdata_i[1:0]);
         ovf_en_o <= wdata_i[EN_BIT];
      end
   end

   // wrap has priority over a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ovf_flag_o <= 1'b0;
      else if (wrap_i)   ovf_flag_o <= 1'b1;
      else if (flag_clr) ovf_flag_o <= 1'b0;
   end

   assign irq_o = ovf_flag_o && ovf_en_o;

   assert_flag_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_i |=> ovf_flag_o);
   assert_flag_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovf_flag_o && !wrap_i) |=> !ovf_flag_o);
   assert_clear_by_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !wrap_i) |=> !ovf_flag_o);
   assert_wrap_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && wrap_i) |=> ovf_flag_o);
endmodule

// File: rtl/freerun_timer.sv
`timescale 1ns/1ps
module freerun_timer
   import freerun_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int NBYTES = CNT_W / DATA_W;

   if (CNT_W != 2 * DATA_W) begin : g_bad_layout
      $error("freerun_timer: count must span exactly two bus bytes");
   end

   ps_sel_e    sel;
   logic       tick;
   logic       wrap;
   logic       ovf_en;
   logic       ovf_flag;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] cnt_byte [NBYTES];

   freerun_ctrl_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (bus_wr),
      .addr_i     (bus_addr),
      .wdata_i    (bus_wdata),
      .wrap_i     (wrap),
      .sel_o      (sel),
      .ovf_en_o   (ovf_en),
      .ovf_flag_o (ovf_flag),
      .irq_o      (irq)
   );

   freerun_prescaler #(.DW(DIV_W)) u_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_i  (sel),
      .tick_o (tick)
   );

   freerun_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick),
      .cnt_o  (cnt),
      .wrap_o (wrap)
   );

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      assign cnt_byte[b] = cnt[b*DATA_W +: DATA_W];
   end

   always_comb begin
      case (bus_addr)
         OFS_CNT_HI: bus_rdata = cnt_byte[NBYTES-1];
         OFS_CNT_LO: bus_rdata = cnt_byte[0];
         OFS_MASK:   bus_rdata = {ovf_en, 5'b0, sel};
         default:    bus_rdata = {ovf_flag, 7'b0};
      endcase
   end

   assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf_en |-> !irq);
   assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf_flag |-> !irq);
endmodule

// File: tb/freerun_timer_bench.sv
`timescale 1ns/1ps
module freerun_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       irq;

   int n_checks = 0;
   int n_errors = 0;

   always #10 clk = ~clk;

   freerun_timer u_freerun_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   function automatic int unsigned ratio(input int s);
      return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 16;
   endfunction

   task automatic check(input string req, input string what,
                        input int unsigned act, input int unsigned exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic step(input int unsigned k);
      repeat (k) @(negedge clk);
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic rd_cnt(output int unsigned c);
      logic [7:0] h, l;
      rd(2'd0, h);
      rd(2'd1, l);
      c = {16'd0, h, l};
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      int unsigned c0, c1, rem;
      logic [7:0] v;
      int restart_order [4] = '{3, 1, 2, 0};

      // R1 reset state
      step(3);
      rd(2'd0, v); check("R1", "count high in reset", v, 0);
      rd(2'd1, v); check("R1", "count low in reset", v, 0);
      rd(2'd2, v); check("R1", "mask in reset", v, 0);
      rd(2'd3, v); check("R1", "flag in reset", v, 0);
      check("R1", "irq in reset", irq, 0);
      rst_n = 1'b1;
      step(10);
      rd_cnt(c0); check("R1", "count 10 edges after reset at ratio 1", c0, 10);

      // R7 / R2: coherent two-byte reads across low-byte carries
      foreach (restart_order[i]) begin
         int unsigned m;
         m = (i == 0) ? 1 : (i == 1) ? 255 : (i == 2) ? 300 : 513;
         rd_cnt(c0);
         step(m);
         rd_cnt(c1);
         check("R7", "high/low byte delta at ratio 1", (c1 - c0) & 32'hFFFF, m);
      end

      // R3: ratio sweep with phase-free windows
      for (int s = 3; s >= 0; s--) begin
         wr(2'd2, 8'(s));
         rd(2'd2, v); check("R3", "mask readback of select", v, s);
         step(20);
         rd_cnt(c0);
         step(32 * ratio(s));
         rd_cnt(c1);
         check("R3", "ticks in 32 ratio periods", (c1 - c0) & 32'hFFFF, 32);
      end

      // R9: divider restart on every select change
      foreach (restart_order[i]) begin
         int s;
         s = restart_order[i];
         wr(2'd2, 8'(s));
         rd_cnt(c0);
         step(ratio(s));
         rd_cnt(c1); check("R9", "no advance during restart period", c1, c0);
         step(1);
         rd_cnt(c1); check("R9", "first advance after restart", c1, (c0 + 1) & 32'hFFFF);
      end

      // R10: writes to count offsets are ignored (ratio 4, 64 edges)
      wr(2'd2, 8'h01);
      step(10);
      rd_cnt(c0);
      wr(2'd0, 8'hAB);
      wr(2'd1, 8'hCD);
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h00);
      step(60);
      rd_cnt(c1);
      check("R10", "count progression despite writes", (c1 - c0) & 32'hFFFF, 16);

      // R4 / R6: overflow at ratio 1 with enable off
      wr(2'd2, 8'h00);
      step(2);
      rd_cnt(c0);
      rem = 65536 - c0;
      step(rem - 1);
      rd_cnt(c1); check("R4", "count just before wrap", c1, 16'hFFFF);
      rd(2'd3, v); check("R4", "flag before wrap", v, 0);
      step(1);
      rd(2'd3, v); check("R4", "flag after wrap", v, 8'h80);
      rd_cnt(c1); check("R4", "count after wrap", c1, 0);
      check("R6", "irq masked while flag set", irq, 0);

      wr(2'd2, 8'h80);
      check("R6", "irq with enable and flag", irq, 1);
      rd(2'd2, v); check("R6", "mask readback of enable", v, 8'h80);

      // R5: write-0 keeps, write-1 clears
      wr(2'd3, 8'h7F);
      rd(2'd3, v); check("R5", "flag kept by write of 0 in bit 7", v, 8'h80);
      wr(2'd3, 8'h80);
      rd(2'd3, v); check("R5", "flag cleared by write of 1", v, 0);
      check("R5", "irq after clear", irq, 0);

      // R8: clear on the wrap edge
      rd_cnt(c0);
      rem = 65536 - c0;
      step(rem - 1);
      rd_cnt(c1); check("R8", "positioned at 0xFFFF", c1, 16'hFFFF);
      wr(2'd3, 8'h80);
      rd(2'd3, v); check("R8", "flag survives clear on wrap edge", v, 8'h80);
      check("R8", "irq survives clear on wrap edge", irq, 1);
      wr(2'd3, 8'h80);
      rd(2'd3, v); check("R8", "later clear takes effect", v, 0);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule